// File: doc/BRIEF.md
# Fractionally Spaced LMS Equalizer

This block is an adaptive FIR equalizer whose time window is always sixteen symbol periods long. It takes a stream of signed samples at a fractional rate and a symbol strobe. A run-time spacing select sets two, three or four samples per symbol. The block produces one filtered sample per symbol. A single physical array of 64 coefficients covers all three spacings: at the coarser spacings only the leading part of the array is active.

The coefficients adapt with the least-mean-squares rule. The error from the downstream slicer arrives two symbols after the output it belongs to. The block therefore keeps a longer sample history and picks the samples that produced that older output. The offset into that history depends on the spacing. A clear control loads a half-scale value into a chosen centre tap and zeros all other taps. A freeze control stops adaption. Two copies of the block, fed from the same samples, form the in-phase and quadrature branches of a receiver.

Top module: `fse_lms_eq`

## Requirements
- R1: After synchronous reset, `y_valid` is 0, `y_out` is 0 and every coefficient is zero, so outputs computed before any clear or update are 0.
- R2: The sample history advances only in cycles with `sample_valid` high. In a cycle with `sample_valid` low, `sym_strobe` and `err_valid` have no effect.
- R3: A cycle with `sample_valid` and `sym_strobe` both high is a firing cycle. One cycle later `y_valid` is high for one cycle and `y_out` holds the low 16 bits of (sum over active taps i of c_i * x_i) arithmetically shifted right by 15. Here x_0 is the sample present in the firing cycle, x_i is the sample accepted i valid samples earlier, and c_i is the coefficient as it stood before that edge. `y_out` holds its value between firing cycles.
- R4: `spacing` encodes 0 = two samples per symbol, 1 = three, 2 or 3 = four. The number of active taps is 16 times the samples per symbol (32, 48 or 64). Taps at or above that index contribute nothing to `y_out`.
- R5: In a firing cycle with `err_valid` high and `freeze` and `clear` low, each active tap i adds (x_(i+2K) * `err_in`) >>> `mu_shift` to its coefficient, with the arithmetic shift taken on the 24-bit product and K the samples per symbol. The error therefore pairs with the samples of the output two strobes earlier.
- R6: A coefficient update that would leave the 16-bit signed range saturates to +32767 or -32768.
- R7: Taps that are inactive in the current spacing keep their coefficient values through updates and become visible again when a wider spacing is selected.
- R8: While `freeze` is high, no coefficient changes, even when an error is presented.
- R9: `clear` high in any cycle sets, at the next edge, all coefficients to 0 except tap `ctr_tap`, which becomes 16384 (+0.5). Clear takes priority over a simultaneous update. An output computed in the same cycle still uses the old coefficients.
- R10: `err_valid` in a cycle that is not a firing cycle causes no update.
- R11: Training against a two-path channel with the error fed back two symbols late lowers the mean squared error by more than four times in every spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Qualifies `sample_in` |
| sample_in | input | 12 | Signed input sample at the fractional rate |
| sym_strobe | input | 1 | Marks the last sample of a symbol |
| spacing | input | 2 | Tap spacing select |
| mu_shift | input | 4 | Step size as right-shift count |
| err_valid | input | 1 | Qualifies `err_in` in a firing cycle |
| err_in | input | 12 | Signed slicer error, two symbols late |
| freeze | input | 1 | Holds all coefficients |
| clear | input | 1 | Loads the centre-tap start state |
| ctr_tap | input | 6 | Index of the tap loaded with +0.5 on clear |
| y_valid | output | 1 | Output strobe, one cycle after a firing cycle |
| y_out | output | 16 | Signed equalized sample |

## Verification
A single strobe edge both forms an output and applies an adaption step. The output must use the coefficients as they stood before that edge, while the update pairs the error with samples offset by twice the spacing factor. The bench presents an error on most strobes in every spacing, so both happen together. Every output is compared with a model that applies the same order: output first, then update. A second overlap is provoked by raising `clear` together with a strobe and an error. The bench then expects the update to be discarded and the pre-clear coefficients to appear in that output.

// File: rtl/fse_pkg.sv
package fse_pkg;

    localparam int DW      = 12;   // sample width
    localparam int CW      = 16;   // coefficient width (Q1.15)
    localparam int EW      = 12;   // error width
    localparam int NTAP    = 64;   // physical taps
    localparam int SPAN    = 16;   // symbols covered
    localparam int ERR_LAT = 2;    // error latency in symbols
    localparam int KMAX    = 4;    // largest samples-per-symbol
    localparam int SLICE   = 16;   // taps per slice
    localparam int MUW     = 4;    // step shift width

    localparam int YW     = DW + 4;
    localparam int LINE   = NTAP + ERR_LAT * KMAX;
    localparam int PRW    = DW + EW;
    localparam int PW     = DW + CW + $clog2(SLICE);
    localparam int AW     = DW + CW + $clog2(NTAP);
    localparam int TW     = $clog2(NTAP);
    localparam int NSLICE = NTAP / SLICE;

    typedef logic signed [DW-1:0]  smp_t;
    typedef logic signed [CW-1:0]  coef_t;
    typedef logic signed [EW-1:0]  err_t;
    typedef logic signed [PRW-1:0] prod_t;

    typedef enum logic [1:0] {
        SP_HALF    = 2'd0,
        SP_THIRD   = 2'd1,
        SP_QUARTER = 2'd2,
        SP_QALT    = 2'd3
    } spacing_e;

    typedef struct packed {
        logic fire;
        logic upd;
        logic clr;
    } ctl_t;

    localparam coef_t CTR_INIT = coef_t'(2 ** (CW - 2));
    localparam logic signed [PRW:0] SAT_HI = (PRW+1)'((2 ** (CW - 1)) - 1);
    localparam logic signed [PRW:0] SAT_LO = (PRW+1)'(-(2 ** (CW - 1)));

    function automatic logic [TW:0] active_taps(spacing_e m);
        case (m)
            SP_HALF:  return (TW+1)'(SPAN * 2);
            SP_THIRD: return (TW+1)'(SPAN * 3);
            default:  return (TW+1)'(SPAN * 4);
        endcase
    endfunction

    function automatic coef_t sat_add(coef_t c, prod_t d);
        logic signed [PRW:0] s;
        s = (PRW+1)'(c) + (PRW+1)'(d);
        if (s > SAT_HI)      return coef_t'(SAT_HI);
        else if (s < SAT_LO) return coef_t'(SAT_LO);
        else                 return coef_t'(s);
    endfunction

endpackage

// File: rtl/fse_delay_line.sv
module fse_delay_line
    import fse_pkg::*;
#(
    parameter int LEN = LINE
) (
    input  logic clk,
    input  logic rst,
    input  logic shift,
    input  smp_t din,
    output smp_t view [LEN]
);

    smp_t hold_q [LEN-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LEN - 1; i++) hold_q[i] <= '0;
        end else if (shift) begin
            hold_q[0] <= din;
            for (int i = 1; i < LEN - 1; i++) hold_q[i] <= hold_q[i-1];
        end
    end

    always_comb begin
        view[0] = din;
        for (int i = 1; i < LEN; i++) view[i] = hold_q[i-1];
    end

endmodule

// File: rtl/fse_tap_slice.sv
module fse_tap_slice
    import fse_pkg::*;
#(
    parameter int N    = SLICE,
    parameter int BASE = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd,
    input  logic                 clr,
    input  logic [TW-1:0]        ctr_tap,
    input  logic [TW:0]          n_act,
    input  smp_t                 x_cur [N],
    input  smp_t                 x_old [N],
    input  err_t                 err,
    input  logic [MUW-1:0]       mu,
    output logic signed [PW-1:0] psum
);

    coef_t      c_q  [N];
    prod_t      step [N];
    logic [N-1:0] act;

    always_comb begin
        for (int g = 0; g < N; g++) begin
            act[g]  = (TW+1)'(BASE + g) < n_act;
            step[g] = (prod_t'(x_old[g]) * prod_t'(err)) >>> mu;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < N; g++) c_q[g] <= '0;
        end else if (clr) begin
            for (int g = 0; g < N; g++)
                c_q[g] <= (ctr_tap == TW'(BASE + g)) ? CTR_INIT : '0;
        end else if (upd) begin
            for (int g = 0; g < N; g++)
                if (act[g]) c_q[g] <= sat_add(c_q[g], step[g]);
        end
    end

    always_comb begin
        psum = '0;
        for (int g = 0; g < N; g++)
            if (act[g]) psum = psum + PW'(c_q[g]) * PW'(x_cur[g]);
    end

endmodule

// File: rtl/fse_lms_eq.sv
module fse_lms_eq
    import fse_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_valid,
    input  logic signed [DW-1:0]    sample_in,
    input  logic                    sym_strobe,
    input  logic [1:0]              spacing,
    input  logic [MUW-1:0]          mu_shift,
    input  logic                    err_valid,
    input  logic signed [EW-1:0]    err_in,
    input  logic                    freeze,
    input  logic                    clear,
    input  logic [TW-1:0]           ctr_tap,
    output logic                    y_valid,
    output logic signed [YW-1:0]    y_out
);

    spacing_e             sp;
    logic [TW:0]          n_act;
    ctl_t                 ctl;
    smp_t                 xv [LINE];
    smp_t                 xa [NTAP];
    logic signed [PW-1:0] psum [NSLICE];
    logic signed [AW-1:0] acc;

    assign sp    = spacing_e'(spacing);
    assign n_act = active_taps(sp);

    assign ctl.fire = sample_valid & sym_strobe;
    assign ctl.clr  = clear;
    assign ctl.upd  = ctl.fire & err_valid & ~freeze;

    fse_delay_line #(.LEN(LINE)) u_line (
        .clk   (clk),
        .rst   (rst),
        .shift (sample_valid),
        .din   (sample_in),
        .view  (xv)
    );

    // samples that produced the output the late error belongs to
    for (genvar i = 0; i < NTAP; i++) begin : g_align
        always_comb begin
            case (sp)
                SP_HALF:  xa[i] = xv[i + ERR_LAT * 2];
                SP_THIRD: xa[i] = xv[i + ERR_LAT * 3];
                default:  xa[i] = xv[i + ERR_LAT * KMAX];
            endcase
        end
    end

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        smp_t xc [SLICE];
        smp_t xo [SLICE];
        for (genvar j = 0; j < SLICE; j++) begin : g_wire
            assign xc[j] = xv[s * SLICE + j];
            assign xo[j] = xa[s * SLICE + j];
        end
        fse_tap_slice #(.N(SLICE), .BASE(s * SLICE)) u_slice (
            .clk     (clk),
            .rst     (rst),
            .upd     (ctl.upd),
            .clr     (ctl.clr),
            .ctr_tap (ctr_tap),
            .n_act   (n_act),
            .x_cur   (xc),
            .x_old   (xo),
            .err     (err_in),
            .mu      (mu_shift),
            .psum    (psum[s])
        );
    end

    always_comb begin
        acc = '0;
        for (int s = 0; s < NSLICE; s++) acc = acc + AW'(psum[s]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_valid <= 1'b0;
            y_out   <= '0;
        end else begin
            y_valid <= ctl.fire;
            if (ctl.fire) y_out <= YW'(acc >>> (CW - 1));
        end
    end

endmodule

// File: rtl/fse_lms_eq_chk.sv
module fse_lms_eq_chk
    import fse_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 fire,
    input logic                 clear,
    input logic [TW-1:0]        ctr_tap,
    input logic [TW:0]          n_act,
    input smp_t                 line_view [LINE],
    input logic                 y_valid,
    input logic signed [YW-1:0] y_out
);

    logic                 clr_q;
    logic signed [YW-1:0] half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_q  <= 1'b0;
            half_q <= '0;
        end else begin
            clr_q <= clear;
            if (fire) half_q <= YW'(line_view[ctr_tap]) >>> 1;
        end
    end

    a_r3_valid_follows_strobe: assert property (@(posedge clk) disable iff (rst)
        fire |=> y_valid);

    a_r3_no_valid_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !y_valid);

    a_r3_output_held: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(y_out));

    a_r9_clear_gives_half_centre: assert property (@(posedge clk) disable iff (rst)
        (clr_q && fire && $stable(ctr_tap) && ({1'b0, ctr_tap} < n_act))
        |=> (y_out == half_q));

endmodule

bind fse_lms_eq fse_lms_eq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fire      (sample_valid & sym_strobe),
    .clear     (clear),
    .ctr_tap   (ctr_tap),
    .n_act     (n_act),
    .line_view (xv),
    .y_valid   (y_valid),
    .y_out     (y_out)
);

// File: tb/fse_lms_eq_tb.sv
module fse_lms_eq_tb;
    import fse_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0, rst = 1'b1;
    logic sv = 1'b0, ss = 1'b0, ev = 1'b0, frz = 1'b0, clr = 1'b0;
    logic signed [DW-1:0] smp = '0;
    logic signed [EW-1:0] err = '0;
    logic [1:0]     spc = 2'd0;
    logic [MUW-1:0] mu  = '0;
    logic [TW-1:0]  ctr = '0;
    logic           yv;
    logic signed [YW-1:0] y;

    always #(CLK_PERIOD/2) clk = ~clk;

    fse_lms_eq u_dut (
        .clk(clk), .rst(rst), .sample_valid(sv), .sample_in(smp), .sym_strobe(ss),
        .spacing(spc), .mu_shift(mu), .err_valid(ev), .err_in(err), .freeze(frz),
        .clear(clr), .ctr_tap(ctr), .y_valid(yv), .y_out(y)
    );

    int    checks = 0, fails = 0;
    string req = "R1";
    int    hist[$];
    int    cf [NTAP];
    logic signed [YW-1:0] m_y = '0;
    logic  m_v = 1'b0;

    function automatic int kof(logic [1:0] s);
        return (s == 2'd0) ? 2 : (s == 2'd1) ? 3 : 4;
    endfunction

    // behavioural reference, applied at each rising edge
    task automatic model_edge();
        int view [LINE];
        int k, nact;
        longint sum;
        logic signed [63:0] t;
        if (rst) begin
            hist = {};
            for (int i = 0; i < LINE - 1; i++) hist.push_back(0);
            for (int i = 0; i < NTAP; i++) cf[i] = 0;
            m_y = '0; m_v = 1'b0;
            return;
        end
        k = kof(spc); nact = SPAN * k;
        view[0] = int'(smp);
        for (int i = 1; i < LINE; i++) view[i] = hist[i-1];
        if (sv && ss) begin
            sum = 0;
            for (int i = 0; i < nact; i++) sum += longint'(cf[i]) * longint'(view[i]);
            t = sum >>> 15;
            m_y = t[YW-1:0];
            m_v = 1'b1;
        end else m_v = 1'b0;
        if (clr) begin
            for (int i = 0; i < NTAP; i++) cf[i] = 0;
            cf[ctr] = 16384;
        end else if (sv && ss && ev && !frz) begin
            for (int i = 0; i < nact; i++) begin
                int d, s;
                d = (view[i + ERR_LAT * k] * int'(err)) >>> mu;
                s = cf[i] + d;
                cf[i] = (s > 32767) ? 32767 : (s < -32768) ? -32768 : s;
            end
        end
        if (sv) begin
            hist.push_front(int'(smp));
            void'(hist.pop_back());
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        checks++;
        if (yv !== m_v || y !== m_y) begin
            fails++;
            $display("FAIL %s: y_valid=%0b y_out=%0d expected y_valid=%0b y_out=%0d",
                     req, yv, y, m_v, m_y);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            sv = 0; ss = 0; ev = 0; clr = 0;
            tick();
        end
    endtask

    task automatic pulse_clear(int tap);
        ctr = TW'(tap); clr = 1; sv = 0; ss = 0; ev = 0;
        tick();
        clr = 0;
    endtask

    // one symbol of random samples; err_mode 0 none, 1 on strobe, 2 off strobe only
    task automatic rand_symbol(int err_mode, int emax);
        int k;
        k = kof(spc);
        for (int p = 0; p < k; p++) begin
            sv  = 1;
            smp = DW'($urandom_range(0, 4095));
            ss  = (p == k - 1);
            ev  = (err_mode == 1) ? (p == k - 1) : (err_mode == 2) ? (p != k - 1) : 1'b0;
            err = EW'(int'($urandom_range(0, 2 * emax)) - emax);
            tick();
        end
        sv = 0; ss = 0; ev = 0;
    endtask

    task automatic train(int s, int nsym);
        int k, d0, a_hist [$], e_hist [$], x, aprev, a;
        longint mse_early, mse_late;
        spc = 2'(s); mu = 4'd13; frz = 0;
        k = kof(spc); d0 = 12 / k;
        pulse_clear(12);
        aprev = 0; mse_early = 0; mse_late = 0;
        for (int n = 0; n < nsym; n++) begin
            int e, dsym;
            a = $urandom_range(0, 1) ? 768 : -768;
            a_hist.push_back(a);
            x = a + ((3 * aprev) >>> 3);
            for (int p = 0; p < k; p++) begin
                sv = 1; smp = DW'(x); ss = (p == k - 1);
                ev = (p == k - 1) && (n >= ERR_LAT);
                err = (n >= ERR_LAT) ? EW'(e_hist[n - ERR_LAT]) : '0;
                tick();
            end
            dsym = (n >= d0) ? a_hist[n - d0] : 0;
            e = dsym - int'(m_y);
            e = (e > 2047) ? 2047 : (e < -2047) ? -2047 : e;
            e_hist.push_back(e);
            if (n >= 10 && n < 60) mse_early += longint'(e) * e;
            if (n >= nsym - 50)    mse_late  += longint'(e) * e;
            aprev = a;
        end
        sv = 0; ss = 0; ev = 0;
        checks++; // R11
        if (!(mse_late * 4 < mse_early)) begin
            fails++;
            $display("FAIL R11: spacing=%0d late_mse_sum=%0d expected below %0d",
                     s, mse_late, mse_early / 4);
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        fails++;
        $display("FAIL %s: watchdog expired, actual running expected finished", req);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, then outputs from all-zero coefficients
        req = "R1";
        for (int i = 0; i < 3; i++) tick();
        rst = 0;
        idle(2);
        for (int i = 0; i < 3; i++) rand_symbol(0, 0);

        // R3: clear to tap 5, filter random data at two samples per symbol
        req = "R3";
        spc = 2'd0;
        pulse_clear(5);
        for (int i = 0; i < 6; i++) rand_symbol(0, 0);

        // R2: strobe and error without sample_valid are ignored
        req = "R2";
        mu = 4'd6;
        for (int i = 0; i < 4; i++) begin
            sv = 0; ss = 1; ev = 1; smp = DW'(1000); err = EW'(500);
            tick();
        end
        ss = 0; ev = 0;
        for (int i = 0; i < 4; i++) rand_symbol(0, 0);

        // R4: centre tap beyond the active range, then widen spacing
        req = "R4";
        spc = 2'd0;
        pulse_clear(40);
        for (int i = 0; i < 4; i++) rand_symbol(0, 0);
        spc = 2'd2;
        for (int i = 0; i < 4; i++) rand_symbol(0, 0);
        spc = 2'd3;
        for (int i = 0; i < 3; i++) rand_symbol(0, 0);
        spc = 2'd1;
        pulse_clear(47);
        for (int i = 0; i < 4; i++) rand_symbol(0, 0);

        // R5: aligned updates in every spacing
        req = "R5";
        for (int s = 0; s < 3; s++) begin
            spc = 2'(s); mu = 4'd9;
            pulse_clear(10);
            for (int i = 0; i < 20; i++) rand_symbol(1, 300);
        end

        // R6: large steps drive coefficients into saturation
        req = "R6";
        spc = 2'd2; mu = 4'd0;
        pulse_clear(20);
        for (int i = 0; i < 12; i++) rand_symbol(1, 2047);

        // R7: inactive taps keep their values across a narrow spacing
        req = "R7";
        mu = 4'd8;
        pulse_clear(50);
        for (int i = 0; i < 10; i++) rand_symbol(1, 400);
        spc = 2'd0;
        for (int i = 0; i < 10; i++) rand_symbol(1, 400);
        spc = 2'd2;
        for (int i = 0; i < 6; i++) rand_symbol(0, 0);

        // R8: freeze blocks updates
        req = "R8";
        frz = 1;
        for (int i = 0; i < 10; i++) rand_symbol(1, 1500);
        frz = 0;
        for (int i = 0; i < 3; i++) rand_symbol(0, 0);

        // R10: error outside firing cycles is ignored
        req = "R10";
        spc = 2'd1;
        for (int i = 0; i < 10; i++) rand_symbol(2, 1500);

        // R9: clear in the same cycle as a strobe with an error
        req = "R9";
        spc = 2'd2; mu = 4'd4;
        for (int i = 0; i < 5; i++) rand_symbol(1, 800);
        for (int p = 0; p < 4; p++) begin
            sv = 1; smp = DW'($urandom_range(0, 4095)); ss = (p == 3);
            ev = (p == 3); err = EW'(900); ctr = TW'(7); clr = (p == 3);
            tick();
        end
        clr = 0; sv = 0; ss = 0; ev = 0;
        for (int i = 0; i < 4; i++) rand_symbol(0, 0);
        frz = 1;
        pulse_clear(33);
        frz = 0;
        for (int i = 0; i < 3; i++) rand_symbol(0, 0);

        // R11: convergence against a two-path channel
        req = "R11";
        for (int s = 0; s < 3; s++) train(s, 400);

        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule